// File: doc/BRIEF.md
# Quad SPI Flash Transfer Sequencer

This block is the master side of a serial flash link. It builds two kinds of frame. The first is a quad-wide fast read. The command goes out on one line. The address, the mode byte and the returned data all use four lines. The second is a quad-input page program. The command and the address go out on one line, and only the write data moves four bits per clock.

The block makes the serial clock, the active-low chip select and a separate output enable for each of the four IO pins. It packs nibbles onto the pins and unpacks the nibbles it receives. Each nibble is placed with its most significant bit on IO3 and its least significant bit on IO0.

On the user side, one start strobe launches a frame. The start strobe samples the operation select, the 24-bit address, the mode byte and the byte count. Received bytes leave with a one-cycle valid strobe. Bytes to be written are pulled in through a ready/valid handshake. The serial clock period is a whole multiple of the system clock, set by a parameter.

Top module: `qspi_seq`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` is 1, `sclk` is 0, `io_oe` is 0000, and `busy`, `done` and `tx_ready` are 0.
- R2: Every frame opens with eight serial clocks that carry the command, most significant bit first. The read command is 0xEB and the program command is 0x32. During these clocks `io_oe` is 0001, so only IO0 is driven.
- R3: In a read, the command is followed by eight clocks with `io_oe` = 1111. Each clock carries one nibble, taken in order from the 32-bit word {address[23:0], mode[7:0]} starting at its top. Bit 3 of each nibble is on IO3 and bit 0 is on IO0.
- R4: In a read, the mode nibbles are followed by four clocks with `io_oe` = 0000. After those, 2·N clocks with `io_oe` = 0000 follow, and `io_in` is sampled on each rising `sclk`. The high nibble of each byte comes first. Each byte appears on `rx_data` with `rx_valid` high for one cycle.
- R5: In a program frame, the command is followed by 24 address bits on IO0 (`io_oe` = 0001), most significant bit first. Then 2·N clocks follow with `io_oe` = 1111, carrying each write byte high nibble first, with bit 3 of the nibble on IO3.
- R6: `cs_n` stays low from the start of a frame until after its last clock. The frame carries exactly 8+8+4+2N (read) or 8+24+2N (program) rising clock edges. `sclk` is 0 whenever `cs_n` is 1.
- R7: Inside a frame, and without a stall, rising `sclk` edges are DIV system clocks apart. `io_out` changes only while `sclk` is low.
- R8: `busy` rises in the cycle after an accepted start and falls in the same cycle that `cs_n` returns high. `done` is high for exactly that one cycle.
- R9: A program frame accepts exactly N bytes through `tx_valid`/`tx_ready`. If a byte has not arrived by the time its high nibble is due, `sclk` is held low with `cs_n` low until the byte arrives.
- R10: A start while `busy` is high, or a start with a byte count of 0, has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| op_prog | input | 1 | 1 = page program, 0 = quad read |
| addr | input | 24 | Flash byte address |
| mode_bits | input | 8 | Mode byte sent after the address in a read |
| byte_cnt | input | CNT_W | Number of data bytes to move (N) |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte is valid |
| tx_ready | output | 1 | Sequencer can take a write byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-pin output enable for IO3..IO0 |
| io_in | input | 4 | Values read from IO3..IO0 |

## Verification
The slot counter and the phase register decide what appears on the pins. If either one slips, the wrong `io_oe` pattern, a shifted nibble or an extra or missing `sclk` edge shows up at the very next rising edge. If the phase register jumps early, the turnaround window at the read data becomes visible as a wrong enable. If the prefetch bookkeeping slips, it shows up within one byte time, in one of three ways: a nibble taken from a stale write byte, a stall that never releases, or a `tx_ready` left high after the frame.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SER,
        PH_QOUT,
        PH_DUMMY,
        PH_DATA
    } phase_e;
endpackage

// File: rtl/qspi_seq_div.sv
module qspi_seq_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_now,
    output logic slot_end
);
    localparam int LO = DIV / 2;
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          sclk_q, sclk_d;

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
        sclk_d = run && (cnt_d >= CW'(LO));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sclk_q <= sclk_d;
        end
    end

    assign sclk     = sclk_q;
    assign rise_now = run && (cnt_q == CW'(LO - 1));
    assign slot_end = run && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/qspi_seq_rxpack.sv
module qspi_seq_rxpack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       hi_half,
    input  logic [3:0] nib,
    output logic [7:0] rx_data,
    output logic       rx_valid
);
    logic [3:0] hi_q, hi_d;
    logic [7:0] byte_q, byte_d;
    logic       vld_q, vld_d;

    always_comb begin
        hi_d   = hi_q;
        byte_d = byte_q;
        vld_d  = 1'b0;
        if (sample) begin
            if (hi_half) begin
                hi_d = nib;
            end else begin
                byte_d = {hi_q, nib};
                vld_d  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            hi_q   <= hi_d;
            byte_q <= byte_d;
            vld_q  <= vld_d;
        end
    end

    assign rx_data  = byte_q;
    assign rx_valid = vld_q;
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_seq_pkg::*;
#(
    parameter int          DIV    = 4,
    parameter int          CNT_W  = 9,
    parameter logic [7:0]  CMD_RD = 8'hEB,
    parameter logic [7:0]  CMD_WR = 8'h32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_prog,
    input  logic [23:0]      addr,
    input  logic [7:0]       mode_bits,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    localparam int LW = (CNT_W + 1 > 6) ? CNT_W + 1 : 6;

    typedef struct packed {
        phase_e           ph;
        logic             prog;
        logic [39:0]      sr;
        logic [LW-1:0]    left;
        logic [CNT_W-1:0] nb;
        logic [CNT_W-1:0] tx_left;
        logic [7:0]       tx_buf;
        logic             tx_full;
        logic             tx_rdy;
        logic             stall;
        logic             run;
        logic             cs_n;
        logic [3:0]       io_o;
        logic [3:0]       io_e;
        logic             busy;
        logic             done;
    } st_t;

    st_t q, d;
    logic rise_now, slot_end;
    logic [39:0] sr_n;
    logic [LW-1:0] data_slots;

    qspi_seq_div #(.DIV(DIV)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.run),
        .sclk     (sclk),
        .rise_now (rise_now),
        .slot_end (slot_end)
    );

    qspi_seq_rxpack rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   ((q.ph == PH_DATA) && !q.prog && rise_now),
        .hi_half  (q.left[0]),
        .nib      (io_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assign data_slots = {q.nb, 1'b0} - LW'(1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sr_n   = q.sr;
        if (q.tx_rdy && tx_valid) begin
            d.tx_buf  = tx_data;
            d.tx_full = 1'b1;
            d.tx_left = q.tx_left - 1'b1;
        end
        if (q.ph == PH_IDLE) begin
            if (start && (byte_cnt != '0)) begin
                d.ph      = PH_SER;
                d.prog    = op_prog;
                d.sr      = {op_prog ? CMD_WR : CMD_RD, addr, mode_bits};
                d.left    = op_prog ? LW'(31) : LW'(7);
                d.nb      = byte_cnt;
                d.tx_left = op_prog ? byte_cnt : '0;
                d.tx_full = 1'b0;
                d.stall   = 1'b0;
                d.run     = 1'b1;
                d.cs_n    = 1'b0;
                d.busy    = 1'b1;
                d.io_o    = {3'b000, op_prog ? CMD_WR[7] : CMD_RD[7]};
                d.io_e    = 4'b0001;
            end
        end else if (q.stall) begin
            if (q.tx_full) begin
                d.stall = 1'b0;
                d.run   = 1'b1;
                d.io_o  = q.tx_buf[7:4];
            end
        end else if (slot_end) begin
            if (q.ph == PH_SER)
                sr_n = q.sr << 1;
            else if (q.ph == PH_QOUT)
                sr_n = q.sr << 4;
            d.sr = sr_n;
            if (q.left != '0) begin
                d.left = q.left - 1'b1;
            end else begin
                case (q.ph)
                    PH_SER: begin
                        d.ph   = q.prog ? PH_DATA : PH_QOUT;
                        d.left = q.prog ? data_slots : LW'(7);
                    end
                    PH_QOUT: begin
                        d.ph   = PH_DUMMY;
                        d.left = LW'(3);
                    end
                    PH_DUMMY: begin
                        d.ph   = PH_DATA;
                        d.left = data_slots;
                    end
                    default: begin
                        d.ph   = PH_IDLE;
                        d.run  = 1'b0;
                        d.cs_n = 1'b1;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                endcase
            end
            case (d.ph)
                PH_SER: begin
                    d.io_o = {3'b000, sr_n[39]};
                    d.io_e = 4'b0001;
                end
                PH_QOUT: begin
                    d.io_o = sr_n[39:36];
                    d.io_e = 4'b1111;
                end
                PH_DATA: begin
                    if (!q.prog) begin
                        d.io_o = 4'b0000;
                        d.io_e = 4'b0000;
                    end else begin
                        d.io_e = 4'b1111;
                        if (d.left[0]) begin
                            if (q.tx_full) begin
                                d.io_o = q.tx_buf[7:4];
                            end else begin
                                d.stall = 1'b1;
                                d.run   = 1'b0;
                            end
                        end else begin
                            d.io_o    = q.tx_buf[3:0];
                            d.tx_full = 1'b0;
                        end
                    end
                end
                default: begin
                    d.io_o = 4'b0000;
                    d.io_e = 4'b0000;
                end
            endcase
        end
        d.tx_rdy = d.busy && d.prog && !d.tx_full && (d.tx_left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_ready = q.tx_rdy;
    assign busy     = q.busy;
    assign done     = q.done;
    assign cs_n     = q.cs_n;
    assign io_out   = q.io_o;
    assign io_oe    = q.io_e;
endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             busy,
    input logic             done,
    input logic             sclk,
    input logic             cs_n,
    input logic [3:0]       io_out,
    input logic [3:0]       io_oe
);
    // R1
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && (io_oe == 4'b0000)));
    // R2
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));
    // R4
    rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (busy && !cs_n));
    // R6
    sclk_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R7
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(io_out));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && cs_n));
    // R9
    tx_ready_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> busy);
    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (byte_cnt != '0)) |=> busy);
endmodule

bind qspi_seq qspi_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byte_cnt (byte_cnt),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .io_out   (io_out),
    .io_oe    (io_oe)
);

// File: tb/qspi_seq_tb.sv
module qspi_seq_tb_top;
    localparam int DIV   = 4;
    localparam int CNT_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_prog = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0] mode_bits = '0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [7:0] rx_data;
    logic rx_valid, busy, done, sclk, cs_n;
    logic [3:0] io_out, io_oe;
    logic [3:0] io_in;

    always #2.5 clk = ~clk;

    qspi_seq #(.DIV(DIV), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
        .addr(addr), .mode_bits(mode_bits), .byte_cnt(byte_cnt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    typedef struct {
        logic [3:0]  oe;
        logic [3:0]  val;
        logic [15:0] req;
    } slot_t;

    slot_t      exp_q[$];
    logic [7:0] rx_exp[$];
    logic [7:0] rd_mem[$];
    int checks = 0;
    int fails = 0;
    int rises = 0;
    int gap = 0;
    bit reading = 0;
    bit allow_stall = 0;
    bit sclk_p = 0;
    bit cs_p = 1;
    bit ended = 0;

    task automatic chk(input bit ok, input logic [15:0] req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: compares pins at every rising serial clock and models the flash
    always @(negedge clk) begin
        if (!rst_n) begin
            io_in = 4'h0;
        end else begin
            gap++;
            if (sclk && !sclk_p) begin
                if (!allow_stall && rises > 0)
                    chk(gap == DIV, "R7", "serial clock period", gap, DIV);
                gap = 0;
                chk(!cs_n, "R6", "clock with cs_n high", cs_n, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "extra serial clock", rises, 0);
                end else begin
                    slot_t e;
                    e = exp_q.pop_front();
                    chk(io_oe == e.oe, e.req, "io_oe", io_oe, e.oe);
                    chk((io_out & io_oe) == e.val, e.req, "io_out", io_out & io_oe, e.val);
                end
                rises++;
            end
            if (!sclk && sclk_p && reading && rises >= 20 && (rises - 20) < 2 * rd_mem.size()) begin
                int j;
                j = rises - 20;
                io_in = (j % 2 == 0) ? rd_mem[j/2][7:4] : rd_mem[j/2][3:0];
            end
            if (rx_valid) begin
                if (rx_exp.size() == 0) chk(0, "R4", "unexpected rx byte", rx_data, 0);
                else begin
                    logic [7:0] b;
                    b = rx_exp.pop_front();
                    chk(rx_data == b, "R4", "rx byte", rx_data, b);
                end
            end
            if (cs_n && !cs_p) begin
                chk(done, "R8", "done at cs release", done, 1);
                chk(!busy, "R8", "busy at cs release", busy, 0);
                chk(exp_q.size() == 0, "R6", "missing serial clocks", exp_q.size(), 0);
            end
            if (!cs_n && cs_p) begin
                rises = 0;
                gap = 0;
            end
            sclk_p = sclk;
            cs_p = cs_n;
        end
    end

    // driver: pushes expected slots, launches the frame, feeds write data
    task automatic do_frame(input bit prog, input logic [23:0] a, input logic [7:0] m,
                            input int n, input bit late, input bit poke);
        logic [7:0] cmd;
        logic [7:0] wr[$];
        logic [31:0] w;
        cmd = prog ? 8'h32 : 8'hEB;
        rd_mem.delete();
        for (int i = 7; i >= 0; i--) exp_q.push_back('{4'b0001, {3'b000, cmd[i]}, "R2"});
        if (prog) begin
            for (int i = 23; i >= 0; i--) exp_q.push_back('{4'b0001, {3'b000, a[i]}, "R5"});
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                wr.push_back(b);
                exp_q.push_back('{4'b1111, b[7:4], "R5"});
                exp_q.push_back('{4'b1111, b[3:0], "R5"});
            end
        end else begin
            w = {a, m};
            for (int i = 0; i < 8; i++) exp_q.push_back('{4'b1111, w[31-4*i -: 4], "R3"});
            for (int i = 0; i < 4; i++) exp_q.push_back('{4'b0000, 4'h0, "R4"});
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                rd_mem.push_back(b);
                rx_exp.push_back(b);
                exp_q.push_back('{4'b0000, 4'h0, "R4"});
                exp_q.push_back('{4'b0000, 4'h0, "R4"});
            end
        end
        reading = !prog;
        allow_stall = late;
        @(negedge clk);
        start = 1'b1; op_prog = prog; addr = a; mode_bits = m; byte_cnt = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1; op_prog = ~prog; addr = 24'h123456; byte_cnt = 9'd7;
            @(negedge clk);
            start = 1'b0;
        end
        if (prog) begin
            if (late) begin
                repeat (300) @(negedge clk);
                chk(rises == 32, "R9", "clocks while stalled", rises, 32);
                chk(!sclk && !cs_n, "R9", "stall holds sclk low, cs low", {sclk, cs_n}, 0);
                chk(tx_ready, "R9", "ready during stall", tx_ready, 1);
            end
            for (int k = 0; k < n; k++) begin
                tx_valid = 1'b1;
                tx_data = wr[k];
                while (!tx_ready) @(negedge clk);
                @(negedge clk);
            end
            tx_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(!tx_ready, "R9", "ready after frame", tx_ready, 0);
        chk(rx_exp.size() == 0, "R4", "bytes not received", rx_exp.size(), 0);
        repeat (5) @(negedge clk);
        chk(cs_n && !sclk && io_oe == 4'b0000, "R1", "idle pins between frames",
            {cs_n, sclk, io_oe}, 6'b100000);
        allow_stall = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n, "R1", "cs_n after reset", cs_n, 1);
        chk(!sclk, "R1", "sclk after reset", sclk, 0);
        chk(io_oe == 4'b0000, "R1", "io_oe after reset", io_oe, 0);
        chk(!busy && !done && !tx_ready, "R1", "status after reset", {busy, done, tx_ready}, 0);

        do_frame(0, 24'hA5C3F0, 8'h5A, 1, 0, 0);
        do_frame(0, 24'h0F1E2D, 8'hC3, 4, 0, 0);
        do_frame(1, 24'h81F00C, 8'h00, 3, 0, 0);
        do_frame(1, 24'h7E0001, 8'h00, 2, 1, 0);
        // R10: second start while busy must not disturb the read frame
        do_frame(0, 24'hFFFFFF, 8'hFF, 2, 0, 1);

        // R10: zero byte count is ignored
        @(negedge clk);
        start = 1'b1; op_prog = 1'b0; byte_cnt = '0;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(cs_n && !busy && !sclk, "R10", "zero-count start ignored", {cs_n, busy, sclk}, 3'b100);

        do_frame(1, 24'h000000, 8'h00, 5, 0, 0);
        finish_run();
    end
endmodule